// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Tracking

This block is the receive half of an asynchronous serial port. It watches a single RX line, brings it into the local clock domain, and uses an oversample tick from an external bit-rate generator to place one sample near the middle of every bit. From those samples it assembles characters of 5 to 8 data bits, least significant bit first. It can check an optional parity bit. The receiver keeps no storage of its own. Each character leaves on `data_o` together with a one-cycle `valid_o` strobe, and a downstream queue or interrupt block is expected to take it from there.

Besides ordinary characters, the receiver treats a break as a condition of its own. A break is a frame in which the start bit, every data bit, the parity bit (when parity is enabled) and the stop position all read low. A break raises a break-start pulse instead of a character. A break-end pulse follows once the line is seen high again. A break never raises a frame error. Parity, stop-bit and start-bit problems on ordinary frames are reported as single-cycle error pulses.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset, `valid_o`, `par_err_o`, `frm_err_o`, `brk_start_o` and `brk_end_o` are 0, `data_o` is 0, and the synchronised line reads idle-high.
- R2: A low level seen at a tick while idle is accepted as a start bit only if the line is still low OVS/2 ticks later. Otherwise the receiver returns to idle and pulses `frm_err_o` alone, without `valid_o`.
- R3: `len_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive LSB first and are placed right-aligned on `data_o`, with unused upper bits 0. Each completed non-break frame gives exactly one `valid_o` pulse.
- R4: With `par_en_i` = 0, no parity bit is expected between the data and the stop bit, and `par_err_o` stays 0.
- R5: With `par_en_i` = 1, the expected parity bit depends on `par_lvl_i`. When `par_lvl_i` = 0, it is the XOR of the received data bits, which is the parity of the count of 1s. When `par_lvl_i` = 1, it is the parity of the count of 0s among the received data bits. A mismatch pulses `par_err_o` in the same cycle as `valid_o`.
- R6: A non-break frame whose stop sample is low still delivers its data with `valid_o`, and pulses `frm_err_o` in that same cycle.
- R7: A frame whose data bits, parity bit (if enabled) and stop sample are all 0 is a break. It pulses `brk_start_o` with no `valid_o`, no `frm_err_o` and no `par_err_o`, and `data_o` keeps its previous value. A zero-data frame with a high stop bit is an ordinary character.
- R8: After a break, `brk_end_o` pulses exactly once, at the first tick on which the synchronised line is high.
- R9: After any frame with a low stop sample, the receiver waits for the line to go high before it looks for a new start bit. A line that stays low therefore produces no further events.
- R10: Every event output is a single-cycle pulse. At most one of `valid_o`, `brk_start_o` and `brk_end_o` is high in any cycle. `data_o` changes only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample tick, OVS ticks per bit, one clock wide |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| len_i | input | 2 | Character length code: 0..3 selects 5..8 data bits |
| par_en_i | input | 1 | Expect and check a parity bit |
| par_lvl_i | input | 1 | 0: parity of the count of 1s, 1: parity of the count of 0s |
| data_o | output | 8 | Last received character, right-aligned |
| valid_o | output | 1 | One-cycle strobe for a new character |
| par_err_o | output | 1 | One-cycle parity mismatch pulse, with valid_o |
| frm_err_o | output | 1 | One-cycle pulse for a rejected start or a low stop bit |
| brk_start_o | output | 1 | One-cycle pulse when a break frame is recognised |
| brk_end_o | output | 1 | One-cycle pulse when the line returns high after a break |

## Verification
The bench probes the boundary between a break and an ordinary frame from several sides:
- A zero-data frame with a high stop bit must be an ordinary character. A receiver that decided on the data bits alone would report a break instead.
- A zero-data frame with a high parity bit must be a character carrying both a parity error and a frame error. A receiver that ignored the parity bit would report a break instead.
- A break whose parity would mismatch must still give no parity error. A receiver that let parity outrank the break would report one.

Glitch starts and low stop bits followed by a long low line are sent to catch two further faults. A receiver that skipped the mid-start recheck would accept the glitch as a character. One that did not wait for the line to go high would produce phantom frames. Parity is exercised at odd and even lengths under both parity levels, so that the count-of-zeros case is tested where it differs from the count-of-ones case. After every break, the held value of `data_o` is compared, which catches a zero character leaking out of the break.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   localparam int unsigned CHAR_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_HOLD
   } rx_state_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] pipe;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) pipe[0] <= 1'b1;
               else         pipe[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) pipe[s] <= 1'b1;
               else         pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
   import serial_rx_pkg::*;
#(
   parameter int unsigned OVS = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic [1:0]        len_i,
   input  logic              par_en_i,
   input  logic              is_brk_i,
   output logic [CHAR_W-1:0] shreg_o,
   output logic              par_bit_o,
   output logic              stop_bit_o,
   output logic              done_o,
   output logic              false_start_o,
   output logic              brk_end_o
);

   localparam int unsigned   CW        = $clog2(OVS);
   localparam logic [CW-1:0] MID_LAST  = CW'(OVS/2 - 1);
   localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);

   rx_state_e         st;
   logic [CW-1:0]     cnt;
   logic [2:0]        idx;
   logic [2:0]        last_idx;
   logic              brk_flag;

   assign last_idx = {1'b0, len_i} + 3'd4;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st            <= ST_IDLE;
         cnt           <= '0;
         idx           <= '0;
         shreg_o       <= '0;
         par_bit_o     <= 1'b0;
         stop_bit_o    <= 1'b1;
         done_o        <= 1'b0;
         false_start_o <= 1'b0;
         brk_end_o     <= 1'b0;
         brk_flag      <= 1'b0;
      end else begin
         done_o        <= 1'b0;
         false_start_o <= 1'b0;
         brk_end_o     <= 1'b0;
         if (done_o) brk_flag <= is_brk_i;
         if (tick_i) begin
            unique case (st)
               ST_IDLE: begin
                  if (!rx_i) begin
                     st  <= ST_START;
                     cnt <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == MID_LAST) begin
                     cnt <= '0;
                     if (!rx_i) begin
                        st      <= ST_DATA;
                        idx     <= '0;
                        shreg_o <= '0;
                     end else begin
                        st            <= ST_IDLE;
                        false_start_o <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == FULL_LAST) begin
                     cnt     <= '0;
                     shreg_o <= {rx_i, shreg_o[CHAR_W-1:1]};
                     if (idx == last_idx) st <= par_en_i ? ST_PAR : ST_STOP;
                     else                 idx <= idx + 3'd1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == FULL_LAST) begin
                     cnt       <= '0;
                     par_bit_o <= rx_i;
                     st        <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == FULL_LAST) begin
                     cnt        <= '0;
                     stop_bit_o <= rx_i;
                     done_o     <= 1'b1;
                     st         <= rx_i ? ST_IDLE : ST_HOLD;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_HOLD: begin
                  if (rx_i && !done_o) begin
                     st        <= ST_IDLE;
                     brk_end_o <= brk_flag;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/serial_rx_judge.sv
module serial_rx_judge
   import serial_rx_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              done_i,
   input  logic              false_start_i,
   input  logic              brk_end_i,
   input  logic [CHAR_W-1:0] shreg_i,
   input  logic [1:0]        len_i,
   input  logic              par_en_i,
   input  logic              par_lvl_i,
   input  logic              par_bit_i,
   input  logic              stop_bit_i,
   output logic              is_brk_o,
   output logic [CHAR_W-1:0] data_o,
   output logic              valid_o,
   output logic              par_err_o,
   output logic              frm_err_o,
   output logic              brk_start_o,
   output logic              brk_end_o
);

   logic [1:0]        shamt;
   logic [CHAR_W-1:0] aligned;
   logic              ones_par;
   logic              exp_par;
   logic              char_ok;

   assign shamt    = 2'd3 - len_i;
   assign aligned  = shreg_i >> shamt;
   assign ones_par = ^aligned;
   // odd lengths (5, 7) flip the parity of the zero count relative to the one count
   assign exp_par  = par_lvl_i ? (ones_par ^ ~len_i[0]) : ones_par;
   assign is_brk_o = (aligned == '0) && (!par_en_i || !par_bit_i) && !stop_bit_i;
   assign char_ok  = done_i && !is_brk_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_o      <= '0;
         valid_o     <= 1'b0;
         par_err_o   <= 1'b0;
         frm_err_o   <= 1'b0;
         brk_start_o <= 1'b0;
         brk_end_o   <= 1'b0;
      end else begin
         if (char_ok) data_o <= aligned;
         valid_o     <= char_ok;
         par_err_o   <= char_ok && par_en_i && (par_bit_i != exp_par);
         frm_err_o   <= (char_ok && !stop_bit_i) || false_start_i;
         brk_start_o <= done_i && is_brk_o;
         brk_end_o   <= brk_end_i;
      end
   end

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
   import serial_rx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic [1:0]        len_i,
   input  logic              par_en_i,
   input  logic              par_lvl_i,
   output logic [CHAR_W-1:0] data_o,
   output logic              valid_o,
   output logic              par_err_o,
   output logic              frm_err_o,
   output logic              brk_start_o,
   output logic              brk_end_o
);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("serial_rx_brk: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_rx_brk: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic [CHAR_W-1:0] shreg;
   logic              par_bit, stop_bit, done, false_start, brk_end_raw, is_brk;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (rx_i),
      .q_o    (rx_s)
   );

   serial_rx_engine #(.OVS(OVS)) u_engine (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tick_i        (tick_i),
      .rx_i          (rx_s),
      .len_i         (len_i),
      .par_en_i      (par_en_i),
      .is_brk_i      (is_brk),
      .shreg_o       (shreg),
      .par_bit_o     (par_bit),
      .stop_bit_o    (stop_bit),
      .done_o        (done),
      .false_start_o (false_start),
      .brk_end_o     (brk_end_raw)
   );

   serial_rx_judge u_judge (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .done_i        (done),
      .false_start_i (false_start),
      .brk_end_i     (brk_end_raw),
      .shreg_i       (shreg),
      .len_i         (len_i),
      .par_en_i      (par_en_i),
      .par_lvl_i     (par_lvl_i),
      .par_bit_i     (par_bit),
      .stop_bit_i    (stop_bit),
      .is_brk_o      (is_brk),
      .data_o        (data_o),
      .valid_o       (valid_o),
      .par_err_o     (par_err_o),
      .frm_err_o     (frm_err_o),
      .brk_start_o   (brk_start_o),
      .brk_end_o     (brk_end_o)
   );

endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [7:0] data_o,
   input logic       valid_o,
   input logic       par_err_o,
   input logic       frm_err_o,
   input logic       brk_start_o,
   input logic       brk_end_o
);

   logic in_brk;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          in_brk <= 1'b0;
      else if (brk_start_o) in_brk <= 1'b1;
      else if (brk_end_o)   in_brk <= 1'b0;
   end

   a_r7_brk_no_frm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_start_o |-> (!frm_err_o && !par_err_o && !valid_o));

   a_r5_par_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      par_err_o |-> valid_o);

   a_r8_end_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_end_o |-> in_brk);

   a_r8_no_start_in_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_start_o |-> !in_brk);

   a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({valid_o, brk_start_o, brk_end_o}));

   a_r10_data_only_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(data_o) |-> valid_o);

   a_r10_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   a_r10_brk_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_start_o |=> !brk_start_o);

endmodule

bind serial_rx_brk serial_rx_brk_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .data_o      (data_o),
   .valid_o     (valid_o),
   .par_err_o   (par_err_o),
   .frm_err_o   (frm_err_o),
   .brk_start_o (brk_start_o),
   .brk_end_o   (brk_end_o)
);

// File: tb/tb_serial_rx_brk.sv
module tb_serial_rx_brk;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rx = 1'b1;
   logic [1:0] len = 2'd3;
   logic       pen = 1'b0;
   logic       plvl = 1'b0;
   logic [7:0] data;
   logic       valid, pe, fe, bs, be;
   logic [1:0] tdiv = 2'd0;

   int n_checks = 0;
   int n_fail = 0;

   logic [12:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  model_data = 8'h00;
   logic [12:0] obs, e;
   string       t;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      tdiv <= tdiv + 2'd1;
      tick <= (tdiv == 2'd3);
   end

   serial_rx_brk dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
      .len_i(len), .par_en_i(pen), .par_lvl_i(plvl),
      .data_o(data), .valid_o(valid), .par_err_o(pe), .frm_err_o(fe),
      .brk_start_o(bs), .brk_end_o(be)
   );

   // every clock: any event must match the head of the expected queue (data_o included)
   always @(negedge clk) begin
      if (rst_n && (valid || pe || fe || bs || be)) begin
         obs = {data, valid, pe, fe, bs, be};
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R10 unexpected event: got %h expected none", obs);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (obs !== e) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", t, obs, e);
            end
         end
      end
   end

   task automatic push(bit v, bit p, bit f, bit s, bit b, logic [7:0] d, string tag);
      if (v) model_data = d;
      exp_q.push_back({model_data, v, p, f, s, b});
      tag_q.push_back(tag);
   endtask

   task automatic bit_time(bit b);
      rx <= b;
      repeat (16 * 4) @(negedge clk);
   endtask

   task automatic settle(string tag);
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL %s: %0d events missing, expected 0", tag, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic frame(logic [7:0] d, int n, bit pbit, bit stopb, int hold_low, string tag);
      logic [7:0] dm;
      int ones;
      bit ep, brk;
      dm   = d & 8'((9'd1 << n) - 9'd1);
      ones = $countones(dm);
      ep   = plvl ? bit'((n - ones) % 2) : bit'(ones % 2);
      brk  = (dm == 8'h00) && (!pen || !pbit) && !stopb;
      if (brk) begin
         push(0, 0, 0, 1, 0, 8'h00, tag);
         push(0, 0, 0, 0, 1, 8'h00, tag);
      end else begin
         push(1, pen && (pbit != ep), !stopb, 0, 0, dm, tag);
      end
      bit_time(1'b0);
      for (int i = 0; i < n; i++) bit_time(d[i]);
      if (pen) bit_time(pbit);
      bit_time(stopb);
      for (int i = 0; i < hold_low; i++) bit_time(1'b0);
      bit_time(1'b1);
      bit_time(1'b1);
      settle(tag);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      n_checks++;
      if ({data, valid, pe, fe, bs, be} !== 13'h0) begin
         n_fail++;
         $display("FAIL R1 reset: got %h expected 0", {data, valid, pe, fe, bs, be});
      end
      repeat (20) @(negedge clk);

      // R3 lengths, LSB first, right-aligned; R4 parity off
      len = 2'd3; pen = 0;
      frame(8'hA5, 8, 0, 1, 0, "R3 8-bit A5");
      frame(8'h3C, 8, 0, 1, 0, "R4 parity off 3C");
      len = 2'd0;
      frame(8'hF3, 5, 0, 1, 0, "R3 5-bit");
      len = 2'd1;
      frame(8'h2D, 6, 0, 1, 0, "R3 6-bit");
      len = 2'd2;
      frame(8'h61, 7, 0, 1, 0, "R3 7-bit");

      // R5 parity over ones and zeros, odd and even lengths
      pen = 1; plvl = 0; len = 2'd3;
      frame(8'hB7, 8, 0, 1, 0, "R5 lvl0 good");
      frame(8'hB7, 8, 1, 1, 0, "R5 lvl0 bad");
      plvl = 1; len = 2'd2;
      frame(8'h55, 7, 1, 1, 0, "R5 lvl1 odd-len good");
      frame(8'h55, 7, 0, 1, 0, "R5 lvl1 odd-len bad");
      len = 2'd3;
      frame(8'h0F, 8, 0, 1, 0, "R5 lvl1 even-len good");
      frame(8'h0F, 8, 1, 1, 0, "R5 lvl1 even-len bad");

      // R6 low stop, R9 line held low afterwards
      pen = 0; plvl = 0;
      frame(8'h81, 8, 0, 0, 3, "R6 R9 low stop");

      // R2 glitch start
      push(0, 0, 1, 0, 0, 8'h00, "R2 false start");
      rx <= 1'b0;
      repeat (4 * 4) @(negedge clk);
      rx <= 1'b1;
      repeat (3 * 64) @(negedge clk);
      settle("R2 false start");

      // R7 R8 break, no parity
      frame(8'h00, 8, 0, 0, 4, "R7 R8 break");
      // R7 zero data with high stop is a character
      frame(8'h00, 8, 0, 1, 0, "R7 zero char");
      // R7 break with parity that would mismatch
      pen = 1; plvl = 1; len = 2'd0;
      frame(8'h00, 5, 0, 0, 2, "R7 break with parity");
      // R7 zero data but high parity bit: character with both errors
      plvl = 0;
      frame(8'h00, 5, 1, 0, 1, "R7 near-break");
      pen = 0; len = 2'd3;
      frame(8'h5A, 8, 0, 1, 0, "R10 after breaks");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule